// File: doc/BRIEF.md
# Shared-Timer Input Debounce Filter

This block cleans up a bank of slow input pins before their levels reach the rest of the chip. Every pin first passes through a multi-stage synchronizer. A small per-pin filter then follows the synchronized level. Its output moves to a new level only after the synchronized input has held that level long enough without a break.

The filter does not store a length per pin. Three period registers form a pool, and each pin picks one of them with a 2-bit index. The high bit of the index lives in one select register and the low bit lives in a second select register, at the pin's own bit position. Index 0 turns filtering off for that pin. A chosen period of zero also turns filtering off. Rewriting a pin's index cancels any count that pin has in progress.

Each pin's filter is a two-state machine:
- `ST_SETTLED`: the output agrees with the input, or filtering is off.
- `ST_PENDING`: the input disagrees with the output and the run is being counted.

The transitions are:
- *start* (SETTLED to PENDING): a mismatch is seen while filtering is on.
- *abort* (PENDING to SETTLED): the input returns to the output level before the period is reached.
- *commit* (PENDING to SETTLED): the period is reached, and the output takes the input level.
- *force* (either state to SETTLED): the index was just rewritten, or the pin is in bypass.

Top module: `pin_debounce_pool`

## Requirements
- R1: After reset, `filt_o` is all zero and every register reads 0. All pins are therefore in bypass.
- R2: Period registers for timers 1, 2 and 3 sit at byte addresses 0x50, 0x54 and 0x58 and keep the low CNT_W bits of the write data. The index high-bit register sits at 0x40 and the index low-bit register at 0x44. `rd_data` shows the addressed register combinationally. Any other address reads 0, and a write to it changes no register.
- R3: Pin i's index is {bit i of 0x40, bit i of 0x44}. Index 1, 2 or 3 selects the period at 0x50, 0x54 or 0x58 respectively.
- R4: A change on `pins_i` reaches the filter after SYNC_STAGES clock edges.
- R5: With index 0, `filt_o[i]` equals the synchronized input one edge later. With the default of two synchronizer stages, an input change is visible after the third edge.
- R6: A selected period of 0 behaves exactly like index 0.
- R7: With period P > 0, `filt_o[i]` takes the synchronized level at the (P+1)-th consecutive edge at which the synchronized input differs from `filt_o[i]`.
- R8: If the synchronized input equals `filt_o[i]` at any edge, the run ends and counting restarts from zero at the next mismatch. A glitch of no more than P synchronized cycles never reaches the output.
- R9: A write to 0x40 or 0x44 that flips pin i's bit clears that pin's run at the following edge, without changing its output. A write that leaves the bit unchanged does not disturb the run.
- R10: Pins that share a timer keep independent runs. Activity on one pin never moves another pin's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the unit of every period |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | NPINS | Raw, unsynchronized pin levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write byte address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read byte address |
| rd_data | output | DATA_W | Read data for `rd_addr` |
| filt_o | output | NPINS | Debounced pin levels |

## Verification
The bench builds the block with NPINS=8, CNT_W=8 and two synchronizer stages. Eight pins are enough to give every timer index, including two pins on the same timer, while leaving spare bits to test the select masks. The 8-bit period width makes it possible to check that the upper bits of a period write are dropped. Periods are kept between 0 and 10, so a single run finishes in a few cycles. This lets thousands of commits, aborts, index changes and zero-period bypasses occur within a short random phase.

// File: rtl/pin_debounce_pkg.sv
package pin_debounce_pkg;

    typedef enum logic {
        ST_SETTLED = 1'b0,
        ST_PENDING = 1'b1
    } dbn_state_e;

    localparam int NUM_TIMERS = 3;
    localparam int IDX_W      = 2;

    typedef logic [IDX_W-1:0] tmr_idx_t;

endpackage

// File: rtl/dbn_sync.sv
module dbn_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];

endmodule

// File: rtl/dbn_regs.sv
module dbn_regs
    import pin_debounce_pkg::*;
#(
    parameter int NPINS    = 32,
    parameter int CNT_W    = 32,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 12,
    parameter int PER_BASE = 'h50,
    parameter int SEL_BASE = 'h40
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_en,
    input  logic [ADDR_W-1:0]                     wr_addr,
    input  logic [DATA_W-1:0]                     wr_data,
    input  logic [ADDR_W-1:0]                     rd_addr,
    output logic [DATA_W-1:0]                     rd_data,
    output logic [NPINS-1:0]                      sel_hi_o,
    output logic [NPINS-1:0]                      sel_lo_o,
    output logic [NUM_TIMERS-1:0][CNT_W-1:0]      period_o,
    output logic [NPINS-1:0]                      clr_o
);

    localparam logic [ADDR_W-1:0] A_SEL_HI = ADDR_W'(SEL_BASE);
    localparam logic [ADDR_W-1:0] A_SEL_LO = ADDR_W'(SEL_BASE + 4);

    logic [NPINS-1:0] new_bits;
    logic             hit_hi;
    logic             hit_lo;

    assign new_bits = wr_data[NPINS-1:0];
    assign hit_hi   = wr_en && (wr_addr == A_SEL_HI);
    assign hit_lo   = wr_en && (wr_addr == A_SEL_LO);

    // index bit registers and the per-pin clear pulse for changed bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_hi_o <= '0;
            sel_lo_o <= '0;
            clr_o    <= '0;
        end else begin
            clr_o <= (hit_hi ? (sel_hi_o ^ new_bits) : '0)
                   | (hit_lo ? (sel_lo_o ^ new_bits) : '0);
            if (hit_hi) sel_hi_o <= new_bits;
            if (hit_lo) sel_lo_o <= new_bits;
        end
    end

    genvar k;
    generate
        for (k = 0; k < NUM_TIMERS; k++) begin : g_period
            localparam logic [ADDR_W-1:0] A_PER = ADDR_W'(PER_BASE + 4 * k);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                          period_o[k] <= '0;
                else if (wr_en && wr_addr == A_PER)  period_o[k] <= wr_data[CNT_W-1:0];
            end
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_SEL_HI) rd_data[NPINS-1:0] = sel_hi_o;
        if (rd_addr == A_SEL_LO) rd_data[NPINS-1:0] = sel_lo_o;
        for (int t = 0; t < NUM_TIMERS; t++) begin
            if (rd_addr == ADDR_W'(PER_BASE + 4 * t)) rd_data[CNT_W-1:0] = period_o[t];
        end
    end

endmodule

// File: rtl/dbn_pin_fsm.sv
module dbn_pin_fsm
    import pin_debounce_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_i,
    input  tmr_idx_t         idx_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic             clr_i,
    output logic             filt_o,
    output logic             pend_o,
    output logic [CNT_W-1:0] cnt_o
);

    dbn_state_e state_q;
    dbn_state_e state_d;
    logic       bypass;
    logic       mismatch;
    logic       expired;

    assign bypass   = (idx_i == '0) || (period_i == '0);
    assign mismatch = (sync_i != filt_o);
    assign expired  = (cnt_o >= period_i);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SETTLED;
        else        state_q <= state_d;
    end

    // next state: start, abort, commit, force
    always_comb begin
        state_d = state_q;
        if (clr_i || bypass) begin
            state_d = ST_SETTLED;
        end else begin
            unique case (state_q)
                ST_SETTLED: if (mismatch) state_d = ST_PENDING;
                ST_PENDING: if (!mismatch || expired) state_d = ST_SETTLED;
                default:    state_d = ST_SETTLED;
            endcase
        end
    end

    // run counter and filtered level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o  <= '0;
            filt_o <= 1'b0;
        end else if (clr_i) begin
            cnt_o <= '0;
        end else if (bypass) begin
            cnt_o  <= '0;
            filt_o <= sync_i;
        end else begin
            unique case (state_q)
                ST_SETTLED: cnt_o <= CNT_W'(mismatch);
                ST_PENDING: begin
                    if (!mismatch) begin
                        cnt_o <= '0;
                    end else if (expired) begin
                        cnt_o  <= '0;
                        filt_o <= sync_i;
                    end else begin
                        cnt_o <= cnt_o + 1'b1;
                    end
                end
                default: cnt_o <= '0;
            endcase
        end
    end

    assign pend_o = (state_q == ST_PENDING);

endmodule

// File: rtl/pin_debounce_pool.sv
module pin_debounce_pool
    import pin_debounce_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int CNT_W       = 32,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 12,
    parameter int SYNC_STAGES = 2,
    parameter int PER_BASE    = 'h50,
    parameter int SEL_BASE    = 'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pins_i,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [NPINS-1:0]  filt_o
);

    logic [NPINS-1:0]                 sync_w;
    logic [NPINS-1:0]                 sel_hi_w;
    logic [NPINS-1:0]                 sel_lo_w;
    logic [NPINS-1:0]                 clr_w;
    logic [NPINS-1:0]                 pend_w;
    logic [NUM_TIMERS-1:0][CNT_W-1:0] per_w;
    logic [NPINS-1:0][CNT_W-1:0]      cnt_w;

    dbn_sync #(
        .WIDTH  (NPINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pins_i),
        .q_o   (sync_w)
    );

    dbn_regs #(
        .NPINS    (NPINS),
        .CNT_W    (CNT_W),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .PER_BASE (PER_BASE),
        .SEL_BASE (SEL_BASE)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .sel_hi_o (sel_hi_w),
        .sel_lo_o (sel_lo_w),
        .period_o (per_w),
        .clr_o    (clr_w)
    );

    genvar i;
    generate
        for (i = 0; i < NPINS; i++) begin : g_pin
            tmr_idx_t         idx;
            logic [CNT_W-1:0] period;

            assign idx = {sel_hi_w[i], sel_lo_w[i]};

            always_comb begin
                unique case (idx)
                    2'd1:    period = per_w[0];
                    2'd2:    period = per_w[1];
                    2'd3:    period = per_w[2];
                    default: period = '0;
                endcase
            end

            dbn_pin_fsm #(
                .CNT_W (CNT_W)
            ) u_fsm (
                .clk      (clk),
                .rst_n    (rst_n),
                .sync_i   (sync_w[i]),
                .idx_i    (idx),
                .period_i (period),
                .clr_i    (clr_w[i]),
                .filt_o   (filt_o[i]),
                .pend_o   (pend_w[i]),
                .cnt_o    (cnt_w[i])
            );
        end
    endgenerate

endmodule

// File: rtl/pin_debounce_chk.sv
module pin_debounce_chk #(
    parameter int NPINS = 32,
    parameter int CNT_W = 32
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NPINS-1:0]            sync_i,
    input logic [NPINS-1:0]            sel_hi_i,
    input logic [NPINS-1:0]            sel_lo_i,
    input logic [2:0][CNT_W-1:0]       per_i,
    input logic [NPINS-1:0]            clr_i,
    input logic [NPINS-1:0]            pend_i,
    input logic [NPINS-1:0][CNT_W-1:0] cnt_i,
    input logic [NPINS-1:0]            filt_i
);

    genvar i;
    generate
        for (i = 0; i < NPINS; i++) begin : g_chk
            logic [1:0]       idx;
            logic [CNT_W-1:0] per;
            logic             byp;

            assign idx = {sel_hi_i[i], sel_lo_i[i]};
            assign per = (idx == 2'd0) ? '0 : per_i[idx - 2'd1];
            assign byp = (idx == 2'd0) || (per == '0);

            // R5 / R6: bypass follows synchronized input after one edge
            p_bypass_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (byp && !clr_i[i]) |=> (filt_i[i] == $past(sync_i[i])));

            // R7: a settled, filtering pin cannot move its output
            p_settled_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (!byp && !clr_i[i] && !pend_i[i]) |=> $stable(filt_i[i]));

            // R8: a bounce back ends the run without an output change
            p_bounce_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (!byp && !clr_i[i] && pend_i[i] && (sync_i[i] == filt_i[i]))
                |=> (!pend_i[i] && $stable(filt_i[i]) && cnt_i[i] == '0));

            // R9: clear settles the pin and holds its output
            p_clear_settles_r9: assert property (@(posedge clk) disable iff (!rst_n)
                clr_i[i] |=> (!pend_i[i] && cnt_i[i] == '0 && $stable(filt_i[i])));

            // R9: a clear only follows a change of this pin's index bits
            p_clear_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
                clr_i[i] |-> (sel_hi_i[i] != $past(sel_hi_i[i]) ||
                              sel_lo_i[i] != $past(sel_lo_i[i])));
        end
    endgenerate

endmodule

bind pin_debounce_pool pin_debounce_chk #(
    .NPINS (NPINS),
    .CNT_W (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_i   (sync_w),
    .sel_hi_i (sel_hi_w),
    .sel_lo_i (sel_lo_w),
    .per_i    (per_w),
    .clr_i    (clr_w),
    .pend_i   (pend_w),
    .cnt_i    (cnt_w),
    .filt_i   (filt_o)
);

// File: tb/pin_debounce_pool_tb_top.sv
module pin_debounce_pool_tb_top;

    localparam int NPINS  = 8;
    localparam int CNT_W  = 8;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NPINS-1:0]  pins = '0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [DATA_W-1:0] rd_data;
    logic [NPINS-1:0]  filt;

    int  total = 0;
    int  bad = 0;
    bit  done = 0;
    bit  mon_on = 0;

    always #10 clk = ~clk;

    pin_debounce_pool #(
        .NPINS (NPINS), .CNT_W (CNT_W), .DATA_W (DATA_W), .ADDR_W (ADDR_W),
        .SYNC_STAGES (2), .PER_BASE ('h50), .SEL_BASE ('h40)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .pins_i (pins),
        .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
        .rd_addr (rd_addr), .rd_data (rd_data), .filt_o (filt)
    );

    // ---------------- reference model, built from the requirements ----------
    logic [CNT_W-1:0] mper [3];
    logic [NPINS-1:0] mhi, mlo, mclr, ms1, ms2, mfilt;
    int               mrun [NPINS];

    function automatic int m_idx(int i);
        return {mhi[i], mlo[i]};
    endfunction

    function automatic int m_per(int i);
        int x = m_idx(i);
        return (x == 0) ? 0 : int'(mper[x-1]);
    endfunction

    function automatic logic [DATA_W-1:0] exp_rd(logic [ADDR_W-1:0] a);
        logic [DATA_W-1:0] r = '0;
        case (a)
            12'h040: r[NPINS-1:0] = mhi;
            12'h044: r[NPINS-1:0] = mlo;
            12'h050: r[CNT_W-1:0] = mper[0];
            12'h054: r[CNT_W-1:0] = mper[1];
            12'h058: r[CNT_W-1:0] = mper[2];
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic string mode_tag(int i);
        if (m_idx(i) == 0) return "R5";
        if (m_per(i) == 0) return "R6";
        return "R7";
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mhi = '0; mlo = '0; mclr = '0; ms1 = '0; ms2 = '0; mfilt = '0;
            for (int k = 0; k < 3; k++) mper[k] = '0;
            for (int i = 0; i < NPINS; i++) mrun[i] = 0;
        end else begin
            logic [NPINS-1:0] nclr;
            for (int i = 0; i < NPINS; i++) begin
                if (mclr[i]) begin
                    mrun[i] = 0;
                end else if (m_per(i) == 0) begin
                    mfilt[i] = ms2[i];
                    mrun[i]  = 0;
                end else if (ms2[i] != mfilt[i]) begin
                    mrun[i] = mrun[i] + 1;
                    if (mrun[i] >= m_per(i) + 1) begin
                        mfilt[i] = ms2[i];
                        mrun[i]  = 0;
                    end
                end else begin
                    mrun[i] = 0;
                end
            end
            ms2 = ms1;
            ms1 = pins;
            nclr = '0;
            if (wr_en) begin
                case (wr_addr)
                    12'h050: mper[0] = wr_data[CNT_W-1:0];
                    12'h054: mper[1] = wr_data[CNT_W-1:0];
                    12'h058: mper[2] = wr_data[CNT_W-1:0];
                    12'h040: begin nclr = nclr | (mhi ^ wr_data[NPINS-1:0]); mhi = wr_data[NPINS-1:0]; end
                    12'h044: begin nclr = nclr | (mlo ^ wr_data[NPINS-1:0]); mlo = wr_data[NPINS-1:0]; end
                    default: ;
                endcase
            end
            mclr = nclr;
        end
    end

    // ---------------- checking helpers ----------------------------------------
    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && mon_on && !done) begin
            for (int i = 0; i < NPINS; i++) begin
                total++;
                if (filt[i] !== mfilt[i]) begin
                    bad++;
                    $display("FAIL %s pin %0d at %0t: actual=%0b expected=%0b",
                             mode_tag(i), i, $time, filt[i], mfilt[i]);
                end
            end
        end
    end

    task automatic bus_wr(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(string tag, logic [ADDR_W-1:0] a);
        rd_addr = a;
        #1;
        check(tag, $sformatf("read 0x%0h", a), rd_data, exp_rd(a));
    endtask

    task automatic wait_n(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // ---------------- watchdog --------------------------------------------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- stimulus ------------------------------------------------
    initial begin
        void'($urandom(32'd20240611));
        wait_n(3);
        check("R1", "filt after reset", 32'(filt), 32'h0);
        rd_addr = 12'h040; #1; check("R1", "sel hi after reset", rd_data, 32'h0);
        rd_addr = 12'h050; #1; check("R1", "period after reset", rd_data, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1;
        wait_n(2);

        // R2: register map, truncation and unmapped address
        bus_wr(12'h050, 32'd3);
        bus_wr(12'h054, 32'd7);
        bus_wr(12'h058, 32'h0001_0005);
        rd_check("R2", 12'h050);
        rd_check("R2", 12'h054);
        check("R2", "period truncated", rd_data, 32'd7);
        rd_addr = 12'h058; #1; check("R2", "period upper bits dropped", rd_data, 32'h5);
        bus_wr(12'h058, 32'd0);
        bus_wr(12'h048, 32'hffff_ffff);
        rd_addr = 12'h048; #1; check("R2", "unmapped read", rd_data, 32'h0);
        rd_addr = 12'h050; #1; check("R2", "period after unmapped write", rd_data, 32'd3);

        // R3: pin0 idx0, pin1 idx1, pin2 idx2, pin3 idx3 (period 0)
        bus_wr(12'h040, 32'h0c);
        bus_wr(12'h044, 32'h0a);
        rd_addr = 12'h040; #1; check("R3", "index high bits", rd_data, 32'h0c);
        rd_addr = 12'h044; #1; check("R3", "index low bits", rd_data, 32'h0a);
        wait_n(4);

        // R4 / R5: bypass latency through synchronizer
        pins[0] = 1'b1;
        wait_n(2); check("R4", "bypass before sync done", 32'(filt[0]), 32'h0);
        wait_n(1); check("R5", "bypass after 3 edges", 32'(filt[0]), 32'h1);

        // R6: zero period acts as bypass
        pins[3] = 1'b1;
        wait_n(3); check("R6", "zero period pin", 32'(filt[3]), 32'h1);

        // R7: period 3 flips at edge 6 after the drive
        pins[1] = 1'b1;
        wait_n(5); check("R7", "before period end", 32'(filt[1]), 32'h0);
        wait_n(1); check("R7", "at period end", 32'(filt[1]), 32'h1);

        // R8: glitch on period-7 pin is swallowed, then a real change lands
        pins[2] = 1'b1; wait_n(5); pins[2] = 1'b0;
        wait_n(15); check("R8", "glitch swallowed", 32'(filt[2]), 32'h0);
        pins[2] = 1'b1;
        wait_n(9);  check("R8", "restart count before end", 32'(filt[2]), 32'h0);
        wait_n(1);  check("R8", "restart count end", 32'(filt[2]), 32'h1);

        // R9: same-value index write does not disturb a run
        pins[1] = 1'b0;
        wait_n(4);
        bus_wr(12'h040, 32'h0c);
        wait_n(1); check("R9", "same-value write keeps run", 32'(filt[1]), 32'h0);

        // R9: changing pin1 from index 1 to index 3 (also period 3) restarts run
        bus_wr(12'h058, 32'd3);
        wait_n(2);
        pins[1] = 1'b1;
        wait_n(4);
        bus_wr(12'h040, 32'h0e);
        for (int k = 6; k <= 9; k++) begin
            wait_n(1); check("R9", $sformatf("cleared run edge %0d", k), 32'(filt[1]), 32'h0);
        end
        wait_n(1); check("R9", "restarted run commit", 32'(filt[1]), 32'h1);

        // R10: pins 4 and 5 share timer 1, only pin 4 moves
        bus_wr(12'h044, 32'h3a);
        wait_n(3);
        pins[4] = 1'b1;
        wait_n(6);
        check("R10", "active pin on shared timer", 32'(filt[4]), 32'h1);
        check("R10", "quiet pin on shared timer", 32'(filt[5]), 32'h0);

        // random phase, checked cycle by cycle by the monitor
        for (int c = 0; c < 6000; c++) begin
            @(negedge clk);
            pins = pins ^ NPINS'($urandom & $urandom & $urandom & $urandom);
            if (($urandom % 120) == 0) begin
                int pick = $urandom % 6;
                logic [ADDR_W-1:0] a;
                logic [DATA_W-1:0] d;
                case (pick)
                    0: a = 12'h050; 1: a = 12'h054; 2: a = 12'h058;
                    3: a = 12'h040; 4: a = 12'h044; default: a = 12'h04c;
                endcase
                d = (pick < 3) ? DATA_W'($urandom % 11) : DATA_W'($urandom);
                bus_wr(a, d);
                rd_check("R2", a);
            end
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule